// File: doc/BRIEF.md
# Nonvolatile SRAM store/recall controller

This block models a byte-wide static RAM that has a shadow nonvolatile copy. Control logic can copy the whole array from the RAM into the shadow copy (STORE) or from the shadow copy back into the RAM (RECALL). In normal operation the RAM is read and written through active-low select, output-enable and write-enable pins. A fourth active-low pin, the store strobe, asks for a STORE.

Two comparator flags describe the supply capacitor. One says the level is below the reset threshold. The other says the level is above the switch threshold. From these flags the block latches a RECALL at power-up and runs it once the supply is good. In automatic mode it also fires one STORE when the supply sags below the switch threshold. A static strap turns off the automatic STORE, and the store strobe still works in that mode. A STORE is only performed when the RAM has been written since the last STORE or RECALL. While either copy runs, the RAM ignores all reads and writes.

Each copy moves one byte per cycle. It then holds the busy output until a parameterised cycle count has elapsed, and that count stands in for the real cell timing.

Top module: `nvsram_ctrl`

## Requirements
- R1: The RAM holds 2^ADDR_W bytes (2048 with the default 11-bit address), and address 0 and address 2047 can each be written and read independently.
- R2: A read is accepted when `sel_n`=0, `rd_en_n`=0, `wr_en_n`=1, `str_n`=1 and `busy`=0. `rdata` and `rdata_vld` then show the byte at `addr` one cycle later. While the pins stay in read state, each new `addr` value is followed on the next cycle, with no pin transition needed.
- R3: A write is accepted when `sel_n`=0, `wr_en_n`=0, `str_n`=1 and `busy`=0. The last address and data seen during the cycle are stored when `sel_n` or `wr_en_n` returns high.
- R4: If `rd_en_n` is low while `wr_en_n` is low, `rdata_vld` is 0 one cycle after `wr_en_n` goes low.
- R5: A RECALL request is latched at reset and whenever `cap_low`=1. It starts when `cap_ok`=1 and `cap_low`=0. `busy` then stays high for exactly RECALL_CYC cycles, after which the RAM holds the shadow contents.
- R6: With `auto_off`=0, a fall of `cap_ok` after power-up starts exactly one STORE, provided the RAM has been written. `charge_en` goes to 0 on the cycle after the fall. Holding `cap_ok` low starts no further STORE.
- R7: With `auto_off`=1, a fall of `cap_ok` starts no STORE and `charge_en` stays 0. A falling edge on `str_n` starts a STORE in either mode, and `busy` stays high for exactly STORE_CYC cycles.
- R8: While `busy`=1, read requests leave `rdata_vld` at 0 and write requests do not change the RAM.
- R9: A STORE request, whether automatic or from `str_n`, is ignored unless a write has completed since the last STORE or RECALL.
- R10: If write pins are still asserted on the cycle a RECALL completes, that write is not applied to the RAM. `wr_err` becomes 1 and stays 1 until reset.
- R11: After reset, `busy`, `rdata_vld`, `charge_en` and `wr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Chip select, active low |
| rd_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| str_n | input | 1 | Store strobe, active low, falling edge requests STORE |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| cap_low | input | 1 | Capacitor level below reset threshold |
| cap_ok | input | 1 | Capacitor level above switch threshold |
| auto_off | input | 1 | Static strap: 1 disables automatic STORE |
| rdata | output | DATA_W | Read data |
| rdata_vld | output | 1 | Read data valid (output drivers on) |
| busy | output | 1 | STORE or RECALL in progress |
| charge_en | output | 1 | Capacitor charging path connected |
| wr_err | output | 1 | Sticky flag: write overlapped RECALL completion |

## Verification
Read data and `rdata_vld` are due one cycle after the pins enter read state, so the driver queues each expected byte at the falling edge where it sets the pins. The monitor compares the byte at the next falling edge that shows `rdata_vld`. Write commits land on the rising edge where the pins are released, so any read queued afterwards sees the new byte. `busy`, `charge_en` and `wr_err` change one rising edge after their trigger. Busy windows are measured by counting the falling edges with `busy`=1 and must equal the copy cycle count exactly. Lockout and ignored STOREs are checked through later reads and through `busy` staying low.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_STORE  = 2'd1,
      OP_RECALL = 2'd2
   } nvs_op_e;
endpackage

// File: rtl/nvs_port.sv
module nvs_port #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              rd_en_n,
   input  logic              wr_en_n,
   input  logic              str_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic              rcl_done,
   output logic              rd_act,
   output logic              rd_vld,
   output logic              commit,
   output logic [ADDR_W-1:0] cm_addr,
   output logic [DATA_W-1:0] cm_data,
   output logic              err
);
   logic wr_pins, wr_act, pend, blk;

   assign wr_pins = !sel_n && !wr_en_n && str_n;
   assign rd_act  = !sel_n && !rd_en_n && wr_en_n && str_n && !busy;
   assign wr_act  = wr_pins && !busy && !blk;
   assign commit  = pend && !wr_act && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         blk     <= 1'b0;
         err     <= 1'b0;
         rd_vld  <= 1'b0;
         cm_addr <= '0;
         cm_data <= '0;
      end else begin
         rd_vld <= rd_act;
         if (rcl_done && wr_pins) begin
            blk <= 1'b1;
            err <= 1'b1;
         end else if (!wr_pins) begin
            blk <= 1'b0;
         end
         if (busy) begin
            pend <= 1'b0;
         end else if (wr_act) begin
            pend    <= 1'b1;
            cm_addr <= addr;
            cm_data <= wdata;
         end else begin
            pend <= 1'b0;
         end
      end
   end

   // R8
   lock_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rd_vld);
   // R10
   late_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rcl_done && wr_pins) |=> (err && !commit));
   // R4
   drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_n && !rd_en_n) |=> !rd_vld);
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
   import nvs_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int STORE_CYC  = 2_500_000,
   parameter int RECALL_CYC = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_store,
   input  logic              go_recall,
   output nvs_op_e           op,
   output logic              busy,
   output logic              copy_en,
   output logic [ADDR_W-1:0] copy_idx,
   output logic              st_done,
   output logic              rc_done
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int MAXD  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
   localparam int CW    = $clog2(MAXD + 1);

   generate
      if (STORE_CYC < DEPTH || RECALL_CYC < DEPTH) begin : g_bad_dur
         $error("copy durations must cover every address");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          last;

   assign busy     = (op != OP_IDLE);
   assign last     = (op == OP_STORE)  ? (cnt == CW'(STORE_CYC - 1))
                                       : (cnt == CW'(RECALL_CYC - 1));
   assign copy_en  = busy && (cnt < CW'(DEPTH));
   assign copy_idx = cnt[ADDR_W-1:0];
   assign st_done  = (op == OP_STORE)  && last;
   assign rc_done  = (op == OP_RECALL) && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op  <= OP_IDLE;
         cnt <= '0;
      end else if (!busy) begin
         cnt <= '0;
         if (go_recall)     op <= OP_RECALL;
         else if (go_store) op <= OP_STORE;
      end else if (last) begin
         op  <= OP_IDLE;
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R5
   dur_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_done || rc_done) |=> !busy);
   // R7
   start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (go_store || go_recall)) |=> busy);
endmodule

// File: rtl/nvs_power.sv
module nvs_power #(
   parameter bit STROBE_ANY_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_low,
   input  logic cap_ok,
   input  logic auto_off,
   input  logic str_n,
   input  logic idle,
   input  logic dirty_eff,
   input  logic rc_started,
   output logic go_store,
   output logic go_recall,
   output logic charge_en
);
   logic str_q, rcl_req, armed, str_fall, str_trig, auto_fire;

   assign str_fall  = str_q && !str_n;
   assign go_recall = rcl_req && cap_ok && !cap_low && idle;
   assign auto_fire = armed && !cap_ok;
   assign go_store  = !go_recall && idle && dirty_eff && (auto_fire || str_trig);

   generate
      if (STROBE_ANY_MODE) begin : g_str_any
         assign str_trig = str_fall;
      end else begin : g_str_inh
         assign str_trig = str_fall && auto_off;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         str_q     <= 1'b1;
         rcl_req   <= 1'b1;
         armed     <= 1'b0;
         charge_en <= 1'b0;
      end else begin
         str_q     <= str_n;
         charge_en <= !auto_off && cap_ok && !cap_low;
         if (cap_low)         rcl_req <= 1'b1;
         else if (rc_started) rcl_req <= 1'b0;
         if (cap_low || !cap_ok)        armed <= 1'b0;
         else if (!auto_off && !rcl_req) armed <= 1'b1;
      end
   end

   // R6
   chg_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_ok) |=> !charge_en);
   // R7
   inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auto_off |-> !armed);
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
   import nvs_pkg::*;
#(
   parameter int ADDR_W          = 11,
   parameter int DATA_W          = 8,
   parameter int STORE_CYC       = 2_500_000,
   parameter int RECALL_CYC      = 5000,
   parameter bit STROBE_ANY_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              rd_en_n,
   input  logic              wr_en_n,
   input  logic              str_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cap_low,
   input  logic              cap_ok,
   input  logic              auto_off,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_vld,
   output logic              busy,
   output logic              charge_en,
   output logic              wr_err
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] ram  [DEPTH];
   logic [DATA_W-1:0] nvm  [DEPTH];

   nvs_op_e           op;
   logic              rd_act, commit, copy_en, st_done, rc_done;
   logic              go_store, go_recall, dirty, dirty_eff;
   logic [ADDR_W-1:0] cm_addr, copy_idx;
   logic [DATA_W-1:0] cm_data;

   assign dirty_eff = dirty || commit;

   nvs_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_en_n(rd_en_n),
      .wr_en_n(wr_en_n), .str_n(str_n), .addr(addr), .wdata(wdata),
      .busy(busy), .rcl_done(rc_done), .rd_act(rd_act), .rd_vld(rdata_vld),
      .commit(commit), .cm_addr(cm_addr), .cm_data(cm_data), .err(wr_err));

   nvs_seq #(.ADDR_W(ADDR_W), .STORE_CYC(STORE_CYC),
             .RECALL_CYC(RECALL_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .go_store(go_store), .go_recall(go_recall),
      .op(op), .busy(busy), .copy_en(copy_en), .copy_idx(copy_idx),
      .st_done(st_done), .rc_done(rc_done));

   nvs_power #(.STROBE_ANY_MODE(STROBE_ANY_MODE)) u_pwr (
      .clk(clk), .rst_n(rst_n), .cap_low(cap_low), .cap_ok(cap_ok),
      .auto_off(auto_off), .str_n(str_n), .idle(!busy),
      .dirty_eff(dirty_eff), .rc_started(go_recall), .go_store(go_store),
      .go_recall(go_recall), .charge_en(charge_en));

   always_ff @(posedge clk) begin
      if (commit)
         ram[cm_addr] <= cm_data;
      else if (copy_en && op == OP_RECALL)
         ram[copy_idx] <= nvm[copy_idx];
      if (copy_en && op == OP_STORE)
         nvm[copy_idx] <= ram[copy_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         dirty <= 1'b0;
      end else begin
         if (rd_act) rdata <= ram[addr];
         if (st_done || rc_done) dirty <= 1'b0;
         else if (commit)        dirty <= 1'b1;
      end
   end

   // R9
   store_needs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_store |-> (dirty || commit));
   // R9
   dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !busy) |=> dirty);
   // R8
   no_commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !commit);
endmodule

// File: tb/nvsram_ctrl_bench.sv
module nvsram_ctrl_bench;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int SC = 2100;
   localparam int RC = 2200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, rd_en_n = 1'b1, wr_en_n = 1'b1, str_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic cap_low = 1'b1, cap_ok = 1'b0, auto_off = 1'b0;
   logic [DW-1:0] rdata;
   logic rdata_vld, busy, charge_en, wr_err;

   always #2 clk = ~clk;

   nvsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYC(SC),
                 .RECALL_CYC(RC)) u_nvsram_ctrl (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_en_n(rd_en_n),
      .wr_en_n(wr_en_n), .str_n(str_n), .addr(addr), .wdata(wdata),
      .cap_low(cap_low), .cap_ok(cap_ok), .auto_off(auto_off),
      .rdata(rdata), .rdata_vld(rdata_vld), .busy(busy),
      .charge_en(charge_en), .wr_err(wr_err));

   typedef struct {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      string         tag;
   } exp_t;

   exp_t          exp_q[$];
   logic [DW-1:0] m_ram [1<<AW];
   logic [DW-1:0] m_nvm [1<<AW];
   int checks = 0, fails = 0;

   task automatic chk(input string tag, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   // monitor: pop one expected byte per valid output cycle
   always @(negedge clk) begin
      if (rst_n && rdata_vld) begin
         if (exp_q.size() == 0) begin
            chk("R2 unexpected rdata_vld", 1'b0, 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, rdata === e.d, int'(rdata), int'(e.d));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk("watchdog", 1'b0, 0, 1);
      report();
   end

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      sel_n = 1'b0; wr_en_n = 1'b0; addr = a; wdata = d;
      @(negedge clk);
      sel_n = 1'b1; wr_en_n = 1'b1;
      m_ram[a] = d;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      @(negedge clk);
      sel_n = 1'b0; rd_en_n = 1'b0; addr = a;
      exp_q.push_back('{a: a, d: m_ram[a], tag: tag});
      @(negedge clk);
      sel_n = 1'b1; rd_en_n = 1'b1;
   endtask

   // counts falling edges with busy high; mode 1 pokes a write and a read,
   // mode 2 holds write pins across the end of the operation
   task automatic run_op(output int n, input int mode);
      n = 0;
      forever begin
         @(negedge clk);
         if (!busy) break;
         n++;
         if (mode == 1 && n == 5) begin
            sel_n = 1'b0; wr_en_n = 1'b0; addr = 11'd5; wdata = 8'hFF;
         end
         if (mode == 1 && n == 7) begin
            sel_n = 1'b1; wr_en_n = 1'b1;
         end
         if (mode == 1 && n == 20) begin
            sel_n = 1'b0; rd_en_n = 1'b0; addr = 11'd5;
         end
         if (mode == 1 && n == 22) begin
            chk("R8 read blocked while busy", rdata_vld == 1'b0, rdata_vld, 0);
            sel_n = 1'b1; rd_en_n = 1'b1;
         end
         if (mode == 2 && n == 5) begin
            sel_n = 1'b0; wr_en_n = 1'b0; addr = 11'd0; wdata = 8'hEE;
         end
      end
   endtask

   task automatic idle_busy(input int cyc, input string tag);
      bit seen;
      seen = 1'b0;
      repeat (cyc) begin
         @(negedge clk);
         if (busy) seen = 1'b1;
      end
      chk(tag, !seen, seen, 0);
   endtask

   initial begin
      int n;
      for (int i = 0; i < (1<<AW); i++) begin
         m_ram[i] = '0;
         m_nvm[i] = '0;
      end
      // phase 1: automatic mode
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 busy after reset", busy == 1'b0, busy, 0);
      chk("R11 rdata_vld after reset", rdata_vld == 1'b0, rdata_vld, 0);
      chk("R11 charge_en after reset", charge_en == 1'b0, charge_en, 0);
      chk("R11 wr_err after reset", wr_err == 1'b0, wr_err, 0);
      cap_low = 1'b0; cap_ok = 1'b1;
      run_op(n, 0);
      chk("R5 power-up recall length", n == RC, n, RC);
      for (int i = 0; i < (1<<AW); i++) m_ram[i] = m_nvm[i];
      chk("R6 charge_en when supply good", charge_en == 1'b1, charge_en, 1);
      wr(11'd5, 8'h3C);
      wr(11'h7FF, 8'hA5);
      wr(11'd0, 8'h11);
      rd(11'd5, "R3 write then read addr 5");
      rd(11'h7FF, "R1 top address");
      rd(11'd0, "R1 bottom address");
      // flow-through: pins held, address changes each cycle
      @(negedge clk);
      sel_n = 1'b0; rd_en_n = 1'b0;
      addr = 11'd0;    exp_q.push_back('{a: 11'd0,    d: m_ram[0],     tag: "R2 follow addr 0"});
      @(negedge clk);
      addr = 11'h7FF;  exp_q.push_back('{a: 11'h7FF,  d: m_ram[11'h7FF], tag: "R2 follow addr 7ff"});
      @(negedge clk);
      addr = 11'd5;    exp_q.push_back('{a: 11'd5,    d: m_ram[5],     tag: "R2 follow addr 5"});
      @(negedge clk);
      sel_n = 1'b1; rd_en_n = 1'b1;
      // write with output enable low
      @(negedge clk);
      @(negedge clk);
      sel_n = 1'b0; rd_en_n = 1'b0; wr_en_n = 1'b0; addr = 11'd5; wdata = 8'h3C;
      @(negedge clk);
      chk("R4 drivers off during write", rdata_vld == 1'b0, rdata_vld, 0);
      sel_n = 1'b1; rd_en_n = 1'b1; wr_en_n = 1'b1;
      // strobe store while dirty, with lockout pokes
      @(negedge clk);
      str_n = 1'b0;
      @(negedge clk);
      str_n = 1'b1;
      chk("R7 strobe store starts", busy == 1'b1, busy, 1);
      run_op(n, 1);
      chk("R7 store length", n == SC - 1, n, SC - 1);
      for (int i = 0; i < (1<<AW); i++) m_nvm[i] = m_ram[i];
      rd(11'd5, "R8 write during store ignored");
      // strobe again with nothing written
      @(negedge clk);
      str_n = 1'b0;
      @(negedge clk);
      str_n = 1'b1;
      idle_busy(8, "R9 clean strobe ignored");
      // sag of the supply in automatic mode
      wr(11'd5, 8'h77);
      @(negedge clk);
      cap_ok = 1'b0;
      @(negedge clk);
      chk("R6 charge path cut", charge_en == 1'b0, charge_en, 0);
      chk("R6 auto store starts", busy == 1'b1, busy, 1);
      run_op(n, 0);
      chk("R6 auto store length", n == SC - 1, n, SC - 1);
      for (int i = 0; i < (1<<AW); i++) m_nvm[i] = m_ram[i];
      idle_busy(10, "R6 only one store while low");
      // phase 2: automatic store disabled
      @(negedge clk);
      rst_n = 1'b0; auto_off = 1'b1; cap_low = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cap_low = 1'b0; cap_ok = 1'b1;
      run_op(n, 0);
      chk("R5 second recall length", n == RC, n, RC);
      for (int i = 0; i < (1<<AW); i++) m_ram[i] = m_nvm[i];
      rd(11'd5, "R5 recalled addr 5");
      rd(11'd0, "R5 recalled addr 0");
      chk("R7 no charging when inhibited", charge_en == 1'b0, charge_en, 0);
      wr(11'd0, 8'h99);
      @(negedge clk);
      cap_ok = 1'b0;
      idle_busy(10, "R7 no auto store when inhibited");
      cap_low = 1'b1;
      repeat (2) @(negedge clk);
      cap_low = 1'b0; cap_ok = 1'b1;
      run_op(n, 0);
      for (int i = 0; i < (1<<AW); i++) m_ram[i] = m_nvm[i];
      rd(11'd0, "R5 recall discards unsaved write");
      // write held across recall completion
      chk("R10 no error yet", wr_err == 1'b0, wr_err, 0);
      @(negedge clk);
      cap_low = 1'b1;
      @(negedge clk);
      cap_low = 1'b0;
      run_op(n, 2);
      repeat (3) @(negedge clk);
      chk("R10 error flag set", wr_err == 1'b1, wr_err, 1);
      sel_n = 1'b1; wr_en_n = 1'b1;
      for (int i = 0; i < (1<<AW); i++) m_ram[i] = m_nvm[i];
      rd(11'd0, "R10 late write not applied");
      @(negedge clk);
      str_n = 1'b0;
      @(negedge clk);
      str_n = 1'b1;
      idle_busy(8, "R9 no store after dropped write");
      chk("R10 error flag sticky", wr_err == 1'b1, wr_err, 1);
      repeat (3) @(negedge clk);
      chk("R2 scoreboard drained", exp_q.size() == 0, exp_q.size(), 0);
      report();
   end
endmodule